// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block sits between an internal single-word memory request port and a slow asynchronous external memory bus. Each accepted request is routed to one of four external banks, and the matching select line is raised while the read or write strobe is active. The strobe is stretched by a wait count (one for reads, one for writes), by an external acknowledge input, or by a mix of the two, as chosen by a two-bit completion code.

All bus timing advances on an I/O tick, which is a clock enable derived from the system clock by a selectable ratio. The block has two bus widths. With the 16-bit bus, one word moves in one strobe. With the 8-bit bus, the controller runs two byte strobes at consecutive byte addresses and assembles or splits the word itself. An external master can claim the bus through a request/grant pair. The controller finishes any access in flight, releases its drivers, and only then grants the bus.

Top module: `xmem_wait_ctrl`

## Requirements
- R1: While a strobe is active, exactly one bank select `ext_sel[n]` is high. Here n is the number of boundaries among `cfg_bound1` ≤ `cfg_bound2` ≤ `cfg_bound3` that are less than or equal to the word address. All selects are low when no strobe is active.
- R2: With completion code 00 (count only), a read strobe lasts `cfg_rd_wait`+1 I/O cycles. A wait of zero therefore gives a strobe of one I/O cycle.
- R3: Write strobes take their length from `cfg_wr_wait` and ignore `cfg_rd_wait`.
- R4: With code 01 (acknowledge only), `ext_ack` is sampled at each I/O tick, starting one I/O cycle after the strobe rises. The strobe ends at the first tick where the sample is high.
- R5: With code 10, a strobe ends only at a tick where the wait count has run out and `ext_ack` is high.
- R6: With code 11, a strobe ends at the first tick where either the wait count has run out or `ext_ack` is high.
- R7: `cfg_div_sel` values 0, 1, 2, 3 and 4 give I/O cycles of 1, 2, 4, 16 and 32 clocks. Values 5 to 7 give 32 clocks. Strobes rise and fall only on I/O ticks.
- R8: With `cfg_bus8`=1, each word uses two strobes. The first is at byte address 2·a and the second at 2·a+1. A write drives the low byte and then the high byte on `ext_dout[7:0]`. A read returns {second byte, first byte} taken from `ext_din[7:0]`.
- R9: Each strobe level is set by its polarity bit: `cfg_rd_pol`/`cfg_wr_pol`=1 means active high. The inactive level is the opposite. Only the strobe that matches the access direction becomes active.
- R10: `req_ready` is high for exactly one clock, in the first clock after the final strobe of a request has ended. `rsp_rdata` holds the read word during that clock.
- R11: When `bus_req` is high, an access in progress finishes first. The address, data and strobe enables then go low, and after that `bus_grant` rises. No strobe runs while the bus is granted. Dropping `bus_req` clears `bus_grant` on the next clock and restores the drivers one clock later.
- R12: With `cfg_bus8`=0, `ext_addr` is the word address with its top bit zero. The full word is driven on `ext_dout` and taken from `ext_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div_sel | input | 3 | I/O clock ratio select |
| cfg_rd_wait | input | WAIT_W | Read wait count |
| cfg_wr_wait | input | WAIT_W | Write wait count |
| cfg_done_mode | input | 2 | Completion code (00 count, 01 ack, 10 both, 11 either) |
| cfg_bus8 | input | 1 | 1 selects the 8-bit external bus |
| cfg_rd_pol | input | 1 | Read strobe active level |
| cfg_wr_pol | input | 1 | Write strobe active level |
| cfg_bound1 | input | AW | Lowest word address of bank 1 |
| cfg_bound2 | input | AW | Lowest word address of bank 2 |
| cfg_bound3 | input | AW | Lowest word address of bank 3 |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read word |
| ext_addr | output | AW+1 | External address (byte address on the 8-bit bus) |
| ext_addr_oe | output | 1 | Address output enable |
| ext_sel | output | 4 | Bank selects, active high |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_strobe_oe | output | 1 | Strobe and select output enable |
| ext_dout | output | 16 | External write data |
| ext_dout_oe | output | 1 | Data output enable |
| ext_din | input | 16 | External read data |
| ext_ack | input | 1 | External acknowledge |
| bus_req | input | 1 | Bus request from an external master |
| bus_grant | output | 1 | Bus granted to the external master |

## Verification
The hardest case to reach is a bus request that arrives while a long strobe is already running. The grant has to wait for the strobe to end, for the return to idle and for the drivers to be released. The bench forks the request off the start of a seven-cycle read strobe. It then watches the grant stay low, rise with the enables low, and fall again when the request is withdrawn. The acknowledge-based completion codes are also delicate, because the sampling ticks interact with the divide ratio. An acknowledge model raises `ext_ack` a set number of clocks into each strobe. The bench predicts the strobe length as a whole number of I/O cycles from that delay and the ratio.

// File: rtl/xmw_pkg.sv
package xmw_pkg;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int NBANK     = 4;
  localparam int MAX_RATIO = 32;
  localparam int DIVSEL_W  = 3;

  typedef enum logic [1:0] {
    DONE_COUNT  = 2'b00,
    DONE_ACK    = 2'b01,
    DONE_BOTH   = 2'b10,
    DONE_EITHER = 2'b11
  } done_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_STROBE = 2'b01,
    ST_GAP    = 2'b10
  } seq_state_e;

  // clocks per I/O cycle for a divider select code
  function automatic int unsigned io_ratio(input logic [DIVSEL_W-1:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 16;
      default: return 32;
    endcase
  endfunction

  // whether a strobe may end at this tick
  function automatic logic access_done(input done_mode_e m, input logic cnt_zero,
                                       input logic ack);
    case (m)
      DONE_COUNT: return cnt_zero;
      DONE_ACK:   return ack;
      DONE_BOTH:  return cnt_zero && ack;
      default:    return cnt_zero || ack;
    endcase
  endfunction
endpackage

// File: rtl/xmw_io_tick.sv
module xmw_io_tick
  import xmw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIVSEL_W-1:0] div_sel,
  output logic                io_en
);
  localparam int CNT_W = $clog2(MAX_RATIO);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim   = CNT_W'(io_ratio(div_sel) - 1);
  assign io_en = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= io_en ? '0 : cnt + 1'b1;
  end

  // R7: ratio one ticks on every clock
  assert_div1_every_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0) |-> io_en);
endmodule

// File: rtl/xmw_bank_decode.sv
module xmw_bank_decode
  import xmw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]             addr,
  input  logic [NBANK-2:0][AW-1:0]  bounds,
  input  logic                      enable,
  output logic [NBANK-1:0]          sel
);
  localparam int IDX_W = $clog2(NBANK);

  logic [NBANK-2:0] above;
  logic [IDX_W-1:0] idx;

  generate
    for (genvar g = 0; g < NBANK - 1; g++) begin : g_cmp
      assign above[g] = (addr >= bounds[g]);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < NBANK - 1; i++) idx = idx + IDX_W'(above[i]);
  end

  assign sel = enable ? (NBANK'(1) << idx) : '0;

  always_comb begin
    assert_sel_onehot_R1: assert ($onehot0(sel));
  end
endmodule

// File: rtl/xmw_bus_handoff.sv
module xmw_bus_handoff (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic seq_idle,
  output logic drive_en,
  output logic bus_grant
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_en  <= 1'b1;
      bus_grant <= 1'b0;
    end else begin
      bus_grant <= bus_req && seq_idle && !drive_en;
      if (bus_req && seq_idle)        drive_en <= 1'b0;
      else if (!bus_req && !bus_grant) drive_en <= 1'b1;
    end
  end

  assert_grant_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !drive_en);
  assert_grant_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> seq_idle);
  assert_grant_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_grant);
endmodule

// File: rtl/xmw_access_seq.sv
module xmw_access_seq
  import xmw_pkg::*;
#(
  parameter int AW     = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              start_allow,
  input  logic [WAIT_W-1:0] rd_wait,
  input  logic [WAIT_W-1:0] wr_wait,
  input  logic [1:0]        done_mode,
  input  logic              bus8,
  input  logic              ext_ack,
  input  logic [WORD_W-1:0] ext_din,
  output logic              req_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              strobe_on,
  output logic              cur_write,
  output logic              seq_idle,
  output logic [AW-1:0]     addr_word,
  output logic              byte_phase,
  output logic [WORD_W-1:0] out_data
);
  localparam int PAD_W = WORD_W - BYTE_W;

  seq_state_e        st;
  done_mode_e        mode;
  logic [WAIT_W-1:0] cnt;
  logic [WORD_W-1:0] wdata_l;
  logic [BYTE_W-1:0] lo_byte;
  logic              start_evt;
  logic              unit_done;
  logic              last_unit;

  assign mode      = done_mode_e'(done_mode);
  assign start_evt = io_en && (st == ST_IDLE) && req_valid && start_allow;
  assign unit_done = io_en && (st == ST_STROBE) && access_done(mode, cnt == '0, ext_ack);
  assign last_unit = !bus8 || byte_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      wdata_l    <= '0;
      lo_byte    <= '0;
      rsp_rdata  <= '0;
      req_ready  <= 1'b0;
      cur_write  <= 1'b0;
      addr_word  <= '0;
      byte_phase <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      if (start_evt) begin
        st         <= ST_STROBE;
        cur_write  <= req_write;
        addr_word  <= req_addr;
        wdata_l    <= req_wdata;
        byte_phase <= 1'b0;
        cnt        <= req_write ? wr_wait : rd_wait;
      end else if (io_en && st == ST_STROBE) begin
        if (unit_done) begin
          st <= ST_GAP;
          if (!cur_write) begin
            if (!last_unit) lo_byte <= ext_din[BYTE_W-1:0];
            else rsp_rdata <= bus8 ? {ext_din[BYTE_W-1:0], lo_byte} : ext_din;
          end
          if (last_unit) req_ready <= 1'b1;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end else if (io_en && st == ST_GAP) begin
        if (!last_unit) begin
          st         <= ST_STROBE;
          byte_phase <= 1'b1;
          cnt        <= cur_write ? wr_wait : rd_wait;
        end else begin
          st <= ST_IDLE;
        end
      end
    end
  end

  assign strobe_on = (st == ST_STROBE);
  assign seq_idle  = (st == ST_IDLE);
  assign out_data  = bus8 ? {{PAD_W{1'b0}},
                             byte_phase ? wdata_l[WORD_W-1:BYTE_W] : wdata_l[BYTE_W-1:0]}
                          : wdata_l;

  assert_count_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && io_en && mode == DONE_COUNT && cnt != '0) |=> strobe_on);
  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && io_en && mode == DONE_ACK && !ext_ack) |=> strobe_on);
  assert_both_need_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && io_en && mode == DONE_BOTH && !ext_ack) |=> strobe_on);
  assert_either_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && io_en && mode == DONE_EITHER && ext_ack) |=> (st == ST_GAP));
  assert_strobe_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |=> $stable(strobe_on));
  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  assert_ready_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !strobe_on);
endmodule

// File: rtl/xmem_wait_ctrl.sv
module xmem_wait_ctrl
  import xmw_pkg::*;
#(
  parameter int AW     = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_div_sel,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  input  logic [WAIT_W-1:0] cfg_wr_wait,
  input  logic [1:0]        cfg_done_mode,
  input  logic              cfg_bus8,
  input  logic              cfg_rd_pol,
  input  logic              cfg_wr_pol,
  input  logic [AW-1:0]     cfg_bound1,
  input  logic [AW-1:0]     cfg_bound2,
  input  logic [AW-1:0]     cfg_bound3,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [15:0]       req_wdata,
  output logic              req_ready,
  output logic [15:0]       rsp_rdata,
  output logic [AW:0]       ext_addr,
  output logic              ext_addr_oe,
  output logic [3:0]        ext_sel,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic              ext_strobe_oe,
  output logic [15:0]       ext_dout,
  output logic              ext_dout_oe,
  input  logic [15:0]       ext_din,
  input  logic              ext_ack,
  input  logic              bus_req,
  output logic              bus_grant
);
  logic                    io_en;
  logic                    drive_en;
  logic                    strobe_on;
  logic                    cur_write;
  logic                    seq_idle;
  logic                    byte_phase;
  logic [AW-1:0]           addr_word;
  logic [WORD_W-1:0]       out_data;
  logic [NBANK-2:0][AW-1:0] bounds;

  assign bounds = {cfg_bound3, cfg_bound2, cfg_bound1};

  xmw_io_tick u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_sel(cfg_div_sel),
    .io_en  (io_en)
  );

  xmw_bus_handoff u_handoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .seq_idle (seq_idle),
    .drive_en (drive_en),
    .bus_grant(bus_grant)
  );

  xmw_access_seq #(.AW(AW), .WAIT_W(WAIT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_en      (io_en),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .start_allow(drive_en && !bus_req),
    .rd_wait    (cfg_rd_wait),
    .wr_wait    (cfg_wr_wait),
    .done_mode  (cfg_done_mode),
    .bus8       (cfg_bus8),
    .ext_ack    (ext_ack),
    .ext_din    (ext_din),
    .req_ready  (req_ready),
    .rsp_rdata  (rsp_rdata),
    .strobe_on  (strobe_on),
    .cur_write  (cur_write),
    .seq_idle   (seq_idle),
    .addr_word  (addr_word),
    .byte_phase (byte_phase),
    .out_data   (out_data)
  );

  xmw_bank_decode #(.AW(AW)) u_bank (
    .addr  (addr_word),
    .bounds(bounds),
    .enable(strobe_on),
    .sel   (ext_sel)
  );

  assign ext_addr      = cfg_bus8 ? {addr_word, byte_phase} : {1'b0, addr_word};
  assign ext_addr_oe   = drive_en;
  assign ext_strobe_oe = drive_en;
  assign ext_dout      = out_data;
  assign ext_dout_oe   = drive_en && cur_write && !seq_idle;
  assign ext_rd        = (strobe_on && !cur_write) ? cfg_rd_pol : !cfg_rd_pol;
  assign ext_wr        = (strobe_on &&  cur_write) ? cfg_wr_pol : !cfg_wr_pol;

  assert_strobe_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> ($countones(ext_sel) == 1));
  assert_granted_bus_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (!ext_addr_oe && !ext_strobe_oe && !ext_dout_oe && !strobe_on));
  assert_word_addr_top_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !cfg_bus8) |-> (ext_addr[AW] == 1'b0));
endmodule

// File: tb/xmem_wait_ctrl_tb_top.sv
module xmem_wait_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEVER      = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_div_sel = 3'd0;
  logic [3:0]  cfg_rd_wait = 4'd0;
  logic [3:0]  cfg_wr_wait = 4'd0;
  logic [1:0]  cfg_done_mode = 2'b00;
  logic        cfg_bus8 = 1'b0;
  logic        cfg_rd_pol = 1'b0;
  logic        cfg_wr_pol = 1'b1;
  logic [15:0] cfg_bound1 = 16'h1000;
  logic [15:0] cfg_bound2 = 16'h4000;
  logic [15:0] cfg_bound3 = 16'h8000;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic [16:0] ext_addr;
  logic        ext_addr_oe;
  logic [3:0]  ext_sel;
  logic        ext_rd, ext_wr, ext_strobe_oe;
  logic [15:0] ext_dout;
  logic        ext_dout_oe;
  logic [15:0] ext_din;
  logic        ext_ack;
  logic        bus_req = 1'b0;
  logic        bus_grant;

  int n_checks = 0;
  int n_fail   = 0;
  int ack_after = NEVER;
  int act_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_wait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div_sel(cfg_div_sel), .cfg_rd_wait(cfg_rd_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_done_mode(cfg_done_mode), .cfg_bus8(cfg_bus8),
    .cfg_rd_pol(cfg_rd_pol), .cfg_wr_pol(cfg_wr_pol), .cfg_bound1(cfg_bound1),
    .cfg_bound2(cfg_bound2), .cfg_bound3(cfg_bound3), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .ext_addr(ext_addr),
    .ext_addr_oe(ext_addr_oe), .ext_sel(ext_sel), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_strobe_oe(ext_strobe_oe), .ext_dout(ext_dout), .ext_dout_oe(ext_dout_oe),
    .ext_din(ext_din), .ext_ack(ext_ack), .bus_req(bus_req), .bus_grant(bus_grant)
  );

  // external memory contents as a function of address
  function automatic logic [15:0] pat(input logic [16:0] x);
    return (x[15:0] * 16'h9E37) ^ 16'h5A5A ^ {15'd0, x[16]};
  endfunction

  function automatic int ratio_of(input logic [2:0] s);
    if (s == 0) return 1;
    if (s == 1) return 2;
    if (s == 2) return 4;
    if (s == 3) return 16;
    return 32;
  endfunction

  function automatic int bank_of(input logic [15:0] a);
    if (a < cfg_bound1) return 0;
    if (a < cfg_bound2) return 1;
    if (a < cfg_bound3) return 2;
    return 3;
  endfunction

  logic strobe_live;
  assign strobe_live = ext_strobe_oe && ((ext_rd == cfg_rd_pol) || (ext_wr == cfg_wr_pol));
  assign ext_din = pat(ext_addr);
  assign ext_ack = strobe_live && (act_cnt >= ack_after);

  always @(posedge clk) act_cnt <= strobe_live ? act_cnt + 1 : 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    bit          wr;
    bit          bus8;
    int          nb;
    int          len;
    logic [16:0] addr0;
    logic [3:0]  sel;
    logic [15:0] wdata;
    logic [15:0] rdata;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  // monitor: strobe recorder and scoreboard
  int          nstb = 0;
  int          cur_len = 0;
  bit          prev_act = 0;
  int          stb_len[2];
  logic [16:0] stb_addr[2];
  logic [3:0]  stb_sel[2];
  bit          stb_wr[2];
  logic [15:0] stb_dout[2];

  always @(negedge clk) begin
    if (strobe_live && !prev_act) begin
      if (nstb < 2) begin
        stb_addr[nstb] = ext_addr;
        stb_sel[nstb]  = ext_sel;
        stb_wr[nstb]   = (ext_wr == cfg_wr_pol);
        stb_dout[nstb] = ext_dout;
      end
      cur_len = 1;
    end else if (strobe_live) begin
      cur_len++;
    end else if (prev_act) begin
      if (nstb < 2) stb_len[nstb] = cur_len;
      nstb++;
    end
    prev_act = strobe_live;
    if (req_ready && rst_n) begin
      if (sb_q.size() == 0) begin
        chk("R10", "unexpected ready", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R10", "strobe idle at ready", strobe_live, 0);
        chk(e.bus8 ? "R8" : e.tag, "strobe count", nstb, e.nb);
        for (int i = 0; i < e.nb && i < nstb; i++) begin
          chk(e.tag, "strobe length", stb_len[i], e.len);
          chk(e.bus8 ? "R8" : "R12", "address", stb_addr[i], e.addr0 + 17'(i));
          chk("R1", "bank select", stb_sel[i], e.sel);
          chk("R9", "strobe direction", stb_wr[i], e.wr);
          if (e.wr && e.bus8)
            chk("R8", "byte data", stb_dout[i][7:0], (i == 0) ? e.wdata[7:0] : e.wdata[15:8]);
          else if (e.wr)
            chk("R12", "word data", stb_dout[i], e.wdata);
        end
        if (!e.wr) chk(e.bus8 ? "R8" : "R12", "read word", rsp_rdata, e.rdata);
      end
      nstb = 0;
    end
  end

  // driver: predicts and enqueues, then runs the handshake
  task automatic do_access(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                           input int ack_a, input string tag);
    exp_t e;
    int r, w, mc, ma, m;
    logic [15:0] b0, b1;
    ack_after = ack_a;
    r  = ratio_of(cfg_div_sel);
    w  = wr ? int'(cfg_wr_wait) : int'(cfg_rd_wait);
    mc = w + 1;
    ma = (ack_a + r) / r;
    case (cfg_done_mode)
      2'b00: m = mc;
      2'b01: m = ma;
      2'b10: m = (mc > ma) ? mc : ma;
      default: m = (mc < ma) ? mc : ma;
    endcase
    b0 = pat({a, 1'b0});
    b1 = pat({a, 1'b1});
    e.wr    = wr;
    e.bus8  = cfg_bus8;
    e.nb    = cfg_bus8 ? 2 : 1;
    e.len   = m * r;
    e.addr0 = cfg_bus8 ? {a, 1'b0} : {1'b0, a};
    e.sel   = 4'b0001 << bank_of(a);
    e.wdata = wd;
    e.rdata = cfg_bus8 ? {b1[7:0], b0[7:0]} : pat({1'b0, a});
    e.tag   = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (1) begin
      @(negedge clk);
      if (req_ready) break;
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "ready width", req_ready, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "ready after reset", req_ready, 0);
    chk("R11", "grant after reset", bus_grant, 0);
    chk("R11", "address enable after reset", ext_addr_oe, 1);
    chk("R1", "selects after reset", ext_sel, 0);
    chk("R9", "read strobe idle level", ext_rd, 1);
    chk("R9", "write strobe idle level", ext_wr, 0);

    // count only, 16-bit bus, all banks
    do_access(0, 16'h0010, 16'h0, NEVER, "R2");
    cfg_rd_wait = 4'd3;
    do_access(0, 16'h2000, 16'h0, NEVER, "R2");
    cfg_wr_wait = 4'd2;
    do_access(1, 16'h5000, 16'hBEEF, NEVER, "R3");
    cfg_rd_wait = 4'd1; cfg_div_sel = 3'd2;
    do_access(0, 16'h9000, 16'h0, NEVER, "R7");
    cfg_wr_wait = 4'd0; cfg_div_sel = 3'd3;
    do_access(1, 16'h0FFF, 16'h1357, NEVER, "R7");
    cfg_rd_wait = 4'd0; cfg_div_sel = 3'd4;
    do_access(0, 16'h1000, 16'h0, NEVER, "R7");
    cfg_div_sel = 3'd6;
    do_access(0, 16'h4000, 16'h0, NEVER, "R7");
    cfg_rd_wait = 4'd1; cfg_div_sel = 3'd1;
    do_access(0, 16'h8000, 16'h0, NEVER, "R7");

    // acknowledge only
    cfg_done_mode = 2'b01; cfg_div_sel = 3'd0; cfg_rd_wait = 4'd0;
    do_access(0, 16'h0123, 16'h0, 3, "R4");
    cfg_div_sel = 3'd2;
    do_access(0, 16'h0124, 16'h0, 5, "R4");
    do_access(1, 16'h0125, 16'hA5A5, 0, "R4");

    // both required
    cfg_done_mode = 2'b10; cfg_div_sel = 3'd0; cfg_rd_wait = 4'd5;
    do_access(0, 16'h3000, 16'h0, 2, "R5");
    cfg_rd_wait = 4'd1;
    do_access(0, 16'h3001, 16'h0, 6, "R5");

    // either sufficient
    cfg_done_mode = 2'b11; cfg_rd_wait = 4'd5;
    do_access(0, 16'h6000, 16'h0, 2, "R6");
    cfg_rd_wait = 4'd1;
    do_access(0, 16'h6001, 16'h0, NEVER, "R6");

    // 8-bit bus
    cfg_done_mode = 2'b00; cfg_bus8 = 1'b1; cfg_rd_wait = 4'd1; cfg_wr_wait = 4'd0;
    do_access(0, 16'h0021, 16'h0, NEVER, "R8");
    do_access(1, 16'h0030, 16'h1234, NEVER, "R8");
    cfg_div_sel = 3'd1;
    do_access(0, 16'h9ABC, 16'h0, NEVER, "R8");
    cfg_bus8 = 1'b0; cfg_div_sel = 3'd0;

    // flipped polarities
    cfg_rd_pol = 1'b1; cfg_wr_pol = 1'b0;
    @(negedge clk);
    chk("R9", "active-high read idle level", ext_rd, 0);
    chk("R9", "active-low write idle level", ext_wr, 1);
    do_access(0, 16'h2222, 16'h0, NEVER, "R9");
    do_access(1, 16'h2223, 16'hC0DE, NEVER, "R9");

    // bus request during a long strobe
    cfg_rd_wait = 4'd6;
    fork
      do_access(0, 16'h0100, 16'h0, NEVER, "R2");
      begin
        @(negedge clk);
        while (!strobe_live) @(negedge clk);
        bus_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk("R11", "grant held off during access", bus_grant, 0);
        end
      end
    join
    begin
      int k;
      k = 0;
      while (!bus_grant && k < 12) begin
        @(negedge clk);
        k++;
      end
    end
    chk("R11", "grant after access", bus_grant, 1);
    chk("R11", "address released", ext_addr_oe, 0);
    chk("R11", "strobes released", ext_strobe_oe, 0);
    chk("R11", "data released", ext_dout_oe, 0);
    repeat (5) @(negedge clk);
    chk("R11", "no strobe while granted", strobe_live, 0);
    bus_req = 1'b0;
    @(negedge clk);
    chk("R11", "grant dropped", bus_grant, 0);
    @(negedge clk);
    chk("R11", "address restored", ext_addr_oe, 1);
    cfg_rd_wait = 4'd0;
    do_access(0, 16'h7777, 16'h0, NEVER, "R11");

    chk("R10", "scoreboard drained", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule